// File: doc/BRIEF.md
# USB Pipe Buffer-Ready Interrupt Aggregator

This block keeps one buffer-ready flag per endpoint pipe of a USB host/function controller and folds them into a single summary interrupt flag and an interrupt request line. The protocol engine reports packet events per pipe: a zero-length packet received, a data packet received, a short packet received, the transaction counter reaching its end, the buffer filling up, and a packet sent and acknowledged with the buffer writable again. Each pipe has an end-of-transfer mode bit. It decides whether every received packet raises the flag or only the packets that end a transfer do.

Software reads the per-pipe flags and clears them by writing zeros. A global clear-mode bit decides what clears the summary flag. In one setting the summary follows the software-visible flags. In the other it follows an internal per-pipe "buffer still ready" state, which drops when the buffer is handed over (`buf_release`). A per-pipe enable masks which set flags may drive the request line.

Top module: `pipe_rdy_irq`

## Requirements
- R1: On a synchronous active-high reset, all per-pipe flags, the internal ready states and the summary flag are 0, and `irq` is 0.
- R2: With `eot_mode[i]`=0, any of `ev_zlp_rx[i]`, `ev_pkt_rx[i]`, `ev_short_rx[i]`, `ev_tc_done[i]` or `ev_buf_full[i]` sets `rdy_sts[i]` at the next clock edge.
- R3: With `eot_mode[i]`=1, `ev_pkt_rx[i]` and `ev_buf_full[i]` alone leave `rdy_sts[i]` unchanged. `ev_short_rx[i]`, `ev_zlp_rx[i]` (a zero-length packet counts as short) and `ev_tc_done[i]` set it.
- R4: `ev_tx_done[i]` sets `rdy_sts[i]` at the next edge, whatever `eot_mode[i]` holds.
- R5: Any event that sets a pipe flag also sets `rdy_sum` at the same clock edge.
- R6: With `clr_mode`=0, `rdy_sum` stays set until the edge at which every bit of `rdy_sts` becomes 0, and it clears at that same edge, whatever the internal ready states hold.
- R7: With `clr_mode`=1, each pipe's internal ready state is set by the same events as its flag and is cleared by `buf_release[i]`. `rdy_sum` clears at the edge at which every internal ready state becomes 0, even while `rdy_sts` bits remain set. `buf_release` never changes `rdy_sts`.
- R8: A cycle with `sts_wr`=1 clears every `rdy_sts` bit whose `sts_wdata` bit is 0 and leaves a bit whose `sts_wdata` bit is 1 unchanged. With `sts_wr`=0, `sts_wdata` has no effect.
- R9: When a set event and a software clear hit the same pipe in one cycle, the flag ends up set.
- R10: `irq` is 1 exactly when `rdy_sum` is 1 and at least one pipe has both `rdy_sts[i]` and `pipe_en[i]` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| eot_mode | input | NUM_PIPES | Per-pipe end-of-transfer mode (1: only transfer-ending receptions set the flag) |
| clr_mode | input | 1 | Summary clear source (0: software flags, 1: internal ready states) |
| pipe_en | input | NUM_PIPES | Per-pipe interrupt enable |
| ev_zlp_rx | input | NUM_PIPES | Zero-length packet received, buffer readable |
| ev_pkt_rx | input | NUM_PIPES | Data packet received, buffer readable |
| ev_short_rx | input | NUM_PIPES | Short packet received |
| ev_tc_done | input | NUM_PIPES | Transaction counter reached its end |
| ev_buf_full | input | NUM_PIPES | Receive buffer became full |
| ev_tx_done | input | NUM_PIPES | Packet sent and acknowledged, buffer writable again |
| buf_release | input | NUM_PIPES | Buffer handed over; drops the internal ready state |
| sts_wr | input | 1 | Software write strobe for the flag register |
| sts_wdata | input | NUM_PIPES | Write data: 0 clears the bit, 1 keeps it |
| rdy_sts | output | NUM_PIPES | Per-pipe buffer-ready flags |
| rdy_sum | output | 1 | Summary buffer-ready flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default of ten pipes, so the top pipe index 9 and a wide mix of pipes whose end-of-transfer modes differ are within reach. With this width, R6 can be shown clearing at the exact edge that empties the last of several flags. R7 can be shown clearing while flags on unrelated pipes stay set. R9 can be driven on one pipe while neighbouring bits are cleared in the same write. A long pseudo-random stretch toggles both mode settings and the enables under sparse events and compares against a behavioural model every cycle.

// File: rtl/prt_pkg.sv
package prt_pkg;

    // Per-pipe registered state: software-visible flag and internal ready state
    typedef struct packed {
        logic ready;
        logic live;
    } pipe_state_t;

    // Summary state
    typedef struct packed {
        logic flag;
    } sum_state_t;

endpackage

// File: rtl/prt_pipe_cell.sv
module prt_pipe_cell
    import prt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic eot_mode,
    input  logic ev_zlp,
    input  logic ev_pkt,
    input  logic ev_short,
    input  logic ev_tc,
    input  logic ev_full,
    input  logic ev_tx,
    input  logic release_buf,
    input  logic sw_clear,
    output logic hit,
    output logic ready_q,
    output logic live_q,
    output logic ready_nx,
    output logic live_nx
);

    pipe_state_t st_d, st_q;
    logic        hit_d;

    always_comb begin
        // Transfer-ending receptions and transmissions always count;
        // plain packets and buffer-full only count in per-packet mode.
        hit_d = ev_tx | ev_short | ev_zlp | ev_tc
              | (~eot_mode & (ev_pkt | ev_full));
        st_d       = st_q;
        st_d.ready = hit_d | (st_q.ready & ~sw_clear);
        st_d.live  = hit_d | (st_q.live & ~release_buf);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign hit      = hit_d;
    assign ready_q  = st_q.ready;
    assign live_q   = st_q.live;
    assign ready_nx = st_d.ready;
    assign live_nx  = st_d.live;

endmodule

// File: rtl/prt_summary.sv
module prt_summary
    import prt_pkg::*;
#(
    parameter int NP = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_mode,
    input  logic [NP-1:0] hit_vec,
    input  logic [NP-1:0] ready_nx,
    input  logic [NP-1:0] live_nx,
    input  logic [NP-1:0] ready_q,
    input  logic [NP-1:0] pipe_en,
    output logic          sum_flag,
    output logic          irq
);

    sum_state_t sum_d, sum_q;
    logic       empty_d;

    always_comb begin
        // Clear source picked by the global mode, judged on next-state values
        empty_d    = clr_mode ? ~(|live_nx) : ~(|ready_nx);
        sum_d      = sum_q;
        sum_d.flag = (|hit_vec) | (sum_q.flag & ~empty_d);
    end

    always_ff @(posedge clk) begin
        if (rst) sum_q <= '0;
        else     sum_q <= sum_d;
    end

    assign sum_flag = sum_q.flag;
    assign irq      = sum_q.flag & (|(ready_q & pipe_en));

endmodule

// File: rtl/pipe_rdy_irq.sv
module pipe_rdy_irq
    import prt_pkg::*;
#(
    parameter int NUM_PIPES = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PIPES-1:0] eot_mode,
    input  logic                 clr_mode,
    input  logic [NUM_PIPES-1:0] pipe_en,
    input  logic [NUM_PIPES-1:0] ev_zlp_rx,
    input  logic [NUM_PIPES-1:0] ev_pkt_rx,
    input  logic [NUM_PIPES-1:0] ev_short_rx,
    input  logic [NUM_PIPES-1:0] ev_tc_done,
    input  logic [NUM_PIPES-1:0] ev_buf_full,
    input  logic [NUM_PIPES-1:0] ev_tx_done,
    input  logic [NUM_PIPES-1:0] buf_release,
    input  logic                 sts_wr,
    input  logic [NUM_PIPES-1:0] sts_wdata,
    output logic [NUM_PIPES-1:0] rdy_sts,
    output logic                 rdy_sum,
    output logic                 irq
);

    localparam int NP = NUM_PIPES;

    logic [NP-1:0] hit_vec;
    logic [NP-1:0] ready_q;
    logic [NP-1:0] live_q;
    logic [NP-1:0] ready_nx;
    logic [NP-1:0] live_nx;
    logic [NP-1:0] clr_vec;

    // Write-zero-to-clear mask
    assign clr_vec = {NP{sts_wr}} & ~sts_wdata;

    for (genvar gi = 0; gi < NP; gi++) begin : g_pipe
        prt_pipe_cell u_cell (
            .clk         (clk),
            .rst         (rst),
            .eot_mode    (eot_mode[gi]),
            .ev_zlp      (ev_zlp_rx[gi]),
            .ev_pkt      (ev_pkt_rx[gi]),
            .ev_short    (ev_short_rx[gi]),
            .ev_tc       (ev_tc_done[gi]),
            .ev_full     (ev_buf_full[gi]),
            .ev_tx       (ev_tx_done[gi]),
            .release_buf (buf_release[gi]),
            .sw_clear    (clr_vec[gi]),
            .hit         (hit_vec[gi]),
            .ready_q     (ready_q[gi]),
            .live_q      (live_q[gi]),
            .ready_nx    (ready_nx[gi]),
            .live_nx     (live_nx[gi])
        );
    end

    prt_summary #(.NP(NP)) u_sum (
        .clk      (clk),
        .rst      (rst),
        .clr_mode (clr_mode),
        .hit_vec  (hit_vec),
        .ready_nx (ready_nx),
        .live_nx  (live_nx),
        .ready_q  (ready_q),
        .pipe_en  (pipe_en),
        .sum_flag (rdy_sum),
        .irq      (irq)
    );

    assign rdy_sts = ready_q;

    // Internal ready states only feed the summary clear path
    logic unused_live;
    assign unused_live = ^live_q;

endmodule

// File: rtl/pipe_rdy_irq_chk.sv
module pipe_rdy_irq_chk #(
    parameter int NP = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          clr_mode,
    input logic [NP-1:0] pipe_en,
    input logic [NP-1:0] ev_tx_done,
    input logic          sts_wr,
    input logic [NP-1:0] sts_wdata,
    input logic [NP-1:0] rdy_sts,
    input logic          rdy_sum,
    input logic          irq
);

    // R1: nothing is asserted while reset is held
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        rst |=> (rdy_sts == '0) || rst);

    // R4 / R5: a transmit completion raises the summary
    a_r5_tx_raises_sum: assert property (@(posedge clk) disable iff (rst)
        (|ev_tx_done) |=> rdy_sum);

    // R4 / R9: a transmit completion leaves its flag set, even against a clear
    a_r9_tx_wins: assert property (@(posedge clk) disable iff (rst)
        (|ev_tx_done) |=> ((rdy_sts & $past(ev_tx_done)) == $past(ev_tx_done)));

    // R6: in software-clear mode the summary only drops with an empty register
    a_r6_sum_falls_empty: assert property (@(posedge clk) disable iff (rst)
        ($fell(rdy_sum) && !$past(clr_mode)) |-> (rdy_sts == '0));

    // R8: no flag disappears without a write of 0 to it
    a_r8_bits_kept: assert property (@(posedge clk) disable iff (rst)
        (!sts_wr || (&sts_wdata)) |=> ((rdy_sts & $past(rdy_sts)) == $past(rdy_sts)));

    // R10: request needs the summary and an enabled set flag
    a_r10_irq_needs_sum: assert property (@(posedge clk) disable iff (rst)
        irq |-> rdy_sum);
    a_r10_irq_needs_enabled: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|(rdy_sts & pipe_en)));

endmodule

bind pipe_rdy_irq pipe_rdy_irq_chk #(.NP(NUM_PIPES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_mode   (clr_mode),
    .pipe_en    (pipe_en),
    .ev_tx_done (ev_tx_done),
    .sts_wr     (sts_wr),
    .sts_wdata  (sts_wdata),
    .rdy_sts    (rdy_sts),
    .rdy_sum    (rdy_sum),
    .irq        (irq)
);

// File: tb/pipe_rdy_irq_tb.sv
module pipe_rdy_irq_tb;

    localparam int NP = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] eot_mode = '0;
    logic          clr_mode = 1'b0;
    logic [NP-1:0] pipe_en = '0;
    logic [NP-1:0] ev_zlp_rx = '0, ev_pkt_rx = '0, ev_short_rx = '0;
    logic [NP-1:0] ev_tc_done = '0, ev_buf_full = '0, ev_tx_done = '0;
    logic [NP-1:0] buf_release = '0;
    logic          sts_wr = 1'b0;
    logic [NP-1:0] sts_wdata = '0;
    logic [NP-1:0] rdy_sts;
    logic          rdy_sum;
    logic          irq;

    always #10 clk = ~clk;

    pipe_rdy_irq #(.NUM_PIPES(NP)) u_dut (
        .clk(clk), .rst(rst), .eot_mode(eot_mode), .clr_mode(clr_mode),
        .pipe_en(pipe_en), .ev_zlp_rx(ev_zlp_rx), .ev_pkt_rx(ev_pkt_rx),
        .ev_short_rx(ev_short_rx), .ev_tc_done(ev_tc_done),
        .ev_buf_full(ev_buf_full), .ev_tx_done(ev_tx_done),
        .buf_release(buf_release), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
        .rdy_sts(rdy_sts), .rdy_sum(rdy_sum), .irq(irq)
    );

    // Behavioural reference model
    bit    m_sts [NP];
    bit    m_live[NP];
    bit    m_sum;
    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    task automatic model_step();
        bit any_hit = 0;
        bit all_sts_zero = 1;
        bit all_live_zero = 1;
        if (rst) begin
            for (int i = 0; i < NP; i++) begin m_sts[i] = 0; m_live[i] = 0; end
            m_sum = 0;
            return;
        end
        for (int i = 0; i < NP; i++) begin
            bit h;
            h = ev_tx_done[i] || ev_short_rx[i] || ev_zlp_rx[i] || ev_tc_done[i];
            if (!eot_mode[i] && (ev_pkt_rx[i] || ev_buf_full[i])) h = 1;
            if (h) begin
                m_sts[i] = 1; m_live[i] = 1; any_hit = 1;
            end else begin
                if (sts_wr && !sts_wdata[i]) m_sts[i] = 0;
                if (buf_release[i]) m_live[i] = 0;
            end
            if (m_sts[i])  all_sts_zero = 0;
            if (m_live[i]) all_live_zero = 0;
        end
        if (any_hit) m_sum = 1;
        else if (m_sum && (clr_mode ? all_live_zero : all_sts_zero)) m_sum = 0;
    endtask

    task automatic check1(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_model();
        logic [NP-1:0] exp_sts;
        bit exp_irq = 0;
        for (int i = 0; i < NP; i++) begin
            exp_sts[i] = m_sts[i];
            if (m_sts[i] && pipe_en[i]) exp_irq = 1;
        end
        exp_irq = exp_irq && m_sum;
        check1(cur_req, "model rdy_sts", int'(rdy_sts), int'(exp_sts));
        check1(cur_req, "model rdy_sum", int'(rdy_sum), int'(m_sum));
        check1("R10", "model irq", int'(irq), int'(exp_irq));
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_model();
        ev_zlp_rx = '0; ev_pkt_rx = '0; ev_short_rx = '0;
        ev_tc_done = '0; ev_buf_full = '0; ev_tx_done = '0;
        buf_release = '0; sts_wr = 1'b0; sts_wdata = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) cycle();
        rst = 1'b0;
        cycle();
        // R1: state after reset
        check1("R1", "rdy_sts", int'(rdy_sts), 0);
        check1("R1", "rdy_sum", int'(rdy_sum), 0);
        check1("R1", "irq", int'(irq), 0);

        // R2: per-packet mode, each event kind on its own pipe
        cur_req = "R2"; pipe_en = '1;
        ev_zlp_rx[0] = 1; cycle();
        check1("R2", "zlp sets pipe0", int'(rdy_sts[0]), 1);
        check1("R5", "summary set", int'(rdy_sum), 1);
        check1("R10", "irq enabled", int'(irq), 1);
        ev_pkt_rx[1] = 1;   cycle(); check1("R2", "pkt sets pipe1", int'(rdy_sts[1]), 1);
        ev_short_rx[2] = 1; cycle(); check1("R2", "short sets pipe2", int'(rdy_sts[2]), 1);
        ev_tc_done[3] = 1;  cycle(); check1("R2", "tc sets pipe3", int'(rdy_sts[3]), 1);
        ev_buf_full[4] = 1; cycle(); check1("R2", "full sets pipe4", int'(rdy_sts[4]), 1);

        // R8 / R6: partial clears keep the summary, the last one drops it
        cur_req = "R8";
        sts_wr = 1; sts_wdata = ~10'b0000000011; cycle();
        check1("R8", "zeros clear", int'(rdy_sts), 'b0000011100);
        check1("R6", "sum held", int'(rdy_sum), 1);
        sts_wr = 1; sts_wdata = '1; cycle();
        check1("R8", "ones keep", int'(rdy_sts), 'b0000011100);
        sts_wr = 0; sts_wdata = '0; cycle();
        check1("R8", "no strobe no effect", int'(rdy_sts), 'b0000011100);
        cur_req = "R6";
        sts_wr = 1; sts_wdata = '0; cycle();
        check1("R6", "last clear", int'(rdy_sts), 0);
        check1("R6", "sum drops same edge", int'(rdy_sum), 0);

        // R3: end-of-transfer mode
        cur_req = "R3"; eot_mode = '1;
        ev_pkt_rx[5] = 1; ev_buf_full[6] = 1; cycle();
        check1("R3", "pkt/full ignored", int'(rdy_sts), 0);
        check1("R3", "sum untouched", int'(rdy_sum), 0);
        ev_short_rx[7] = 1; ev_tc_done[8] = 1; ev_zlp_rx[6] = 1; cycle();
        check1("R3", "short/tc/zlp set", int'(rdy_sts), 'b0111000000);

        // R4: transmit in both modes
        cur_req = "R4";
        ev_tx_done[9] = 1; cycle();
        check1("R4", "tx eot=1 pipe9", int'(rdy_sts[9]), 1);
        eot_mode[5] = 0; ev_tx_done[5] = 1; cycle();
        check1("R4", "tx eot=0 pipe5", int'(rdy_sts[5]), 1);

        // R10: enables
        cur_req = "R10";
        pipe_en = 10'b0000000001; cycle();
        check1("R10", "no enabled flag", int'(irq), 0);
        pipe_en = 10'b1000000000; cycle();
        check1("R10", "pipe9 enabled", int'(irq), 1);

        // R7: clear from the internal ready states
        cur_req = "R7"; clr_mode = 1;
        buf_release = '1; cycle();
        check1("R7", "sum drops", int'(rdy_sum), 0);
        check1("R7", "flags untouched", int'(rdy_sts), 'b1111100000);
        check1("R7", "irq low", int'(irq), 0);
        ev_tx_done[3] = 1; cycle();
        buf_release[1] = 1; cycle();
        check1("R7", "other release keeps", int'(rdy_sum), 1);
        buf_release[3] = 1; cycle();
        check1("R7", "release pipe3 drops", int'(rdy_sum), 0);

        // R9: set beats clear on the same pipe
        cur_req = "R9"; clr_mode = 0;
        sts_wr = 1; sts_wdata = '0; ev_tx_done[2] = 1; cycle();
        check1("R9", "set wins", int'(rdy_sts), 'b0000000100);
        check1("R5", "sum set", int'(rdy_sum), 1);

        // Mixed pseudo-random stretch
        cur_req = "R2/R3/R7/R8 random";
        for (int k = 0; k < 2000; k++) begin
            if (k % 50 == 0) begin
                eot_mode = NP'($urandom); clr_mode = $urandom_range(0, 1);
                pipe_en = NP'($urandom);
            end
            ev_zlp_rx   = NP'($urandom & $urandom & $urandom & $urandom);
            ev_pkt_rx   = NP'($urandom & $urandom & $urandom);
            ev_short_rx = NP'($urandom & $urandom & $urandom & $urandom);
            ev_tc_done  = NP'($urandom & $urandom & $urandom & $urandom);
            ev_buf_full = NP'($urandom & $urandom & $urandom & $urandom);
            ev_tx_done  = NP'($urandom & $urandom & $urandom & $urandom);
            buf_release = NP'($urandom | $urandom);
            sts_wr      = ($urandom_range(0, 3) == 0);
            sts_wdata   = NP'($urandom & $urandom);
            cycle();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule